// File: doc/BRIEF.md
# Byte-Lane RAM with Held Address

A synchronous, single-clock, single-port memory whose word is divided into 8-bit lanes, each with its own write-enable bit. Every access is presented on the inputs and taken at one rising clock edge. The result appears on a registered output `q` after that same edge. Only the lanes whose enable bit is set are changed by a write. The rest of the stored word is left as it was.

During a write, `q` is built one lane at a time. A lane that is not enabled shows the byte that was already stored. An enabled lane shows either the byte just written or the byte it replaced. The parameter `NEW_ON_WRITE` picks which of the two at build time.

The address register has an active-low load enable, `addressstall`. While it is high, the register keeps the address it captured earlier, and every read and write in those cycles goes to that held address.

Top module: `bytelane_ram`

## Requirements
- R1: While `rst_n` is low, `q` is cleared to zero and the address register is cleared to zero. A stalled access right after reset therefore goes to address 0.
- R2: Bit i of `byteena` controls data bits [8i+7:8i]. A write (`wren`=1) stores only the lanes whose bit is 1. The other lanes keep their contents.
- R3: During a write, each lane whose `byteena` bit is 0 shows the old stored byte on `q` after the edge.
- R4: With `NEW_ON_WRITE`=1, each enabled lane shows the written byte. Example: a word holding 0xABCD is written with 0xFFFF. With `byteena`=2'b10, both the stored value and `q` become 0xFFCD. With 2'b01, both become 0xABFF. With 2'b11, `q` equals the write data.
- R5: With `NEW_ON_WRITE`=0, each enabled lane shows the contents from before the write, while the memory is still updated.
- R6: With `wren`=0 and `rden`=1, `q` shows the word at the access address after the next edge.
- R7: With `wren`=0 and `rden`=0, `q` holds its value.
- R8: While `addressstall`=1, the address register keeps its value, and reads and writes use that held address over any number of cycles. When `addressstall`=0, the register loads `addr`.
- R9: Every result is due on `q` exactly one rising edge after its inputs are sampled, at every address including the lowest and highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of output and address register |
| addr | input | ADDR_W | Access address |
| data | input | DATA_W | Write data |
| wren | input | 1 | Write request |
| rden | input | 1 | Read request |
| byteena | input | DATA_W/8 | Per-lane write enable |
| addressstall | input | 1 | When high, the address register keeps its value |
| q | output | DATA_W | Registered read data |

## Verification
Each result is due one rising edge after its inputs: the lane view on `q` for a write, the stored word for a read, and the new value of the address register. Reads, writes and stalls are the same in this respect. The bench drives its inputs on the falling edge and lets exactly one rising edge pass. At the next falling edge it compares `q` of two instances, one in each write-view mode, against a behavioural array model that has advanced by one access. The bound checker relates each output lane to the inputs and the old word one cycle earlier.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int LANE_W = 8;

  // Byte shown on the output for one lane in the cycle of an access.
  function automatic logic [LANE_W-1:0] lane_view(
    input logic [LANE_W-1:0] stored_b,
    input logic [LANE_W-1:0] write_b,
    input logic              wr,
    input logic              en,
    input logic              show_new
  );
    return (wr && en && show_new) ? write_b : stored_b;
  endfunction

  // Address used by an access, given the stall input.
  function automatic logic [31:0] pick_addr(
    input logic [31:0] held,
    input logic [31:0] fresh,
    input logic        stall
  );
    return stall ? held : fresh;
  endfunction
endpackage

// File: rtl/bram_addr_stage.sv
module bram_addr_stage #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              stall,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] addr_lat
);
  import bram_pkg::*;

  logic [31:0] picked;

  assign picked   = pick_addr(32'(addr_lat), 32'(addr_in), stall);
  assign eff_addr = picked[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) addr_lat <= '0;
    else        addr_lat <= eff_addr;
  end
endmodule

// File: rtl/bram_lane.sv
module bram_lane #(
  parameter int ADDR_W       = 4,
  parameter bit NEW_ON_WRITE = 1'b1
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wren,
  input  logic              lane_en,
  input  logic [7:0]        wbyte,
  output logic [7:0]        old_byte,
  output logic [7:0]        view_byte
);
  import bram_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];
  logic       lane_wr;

  assign lane_wr   = wren && lane_en;
  assign old_byte  = cells[addr];
  assign view_byte = lane_view(old_byte, wbyte, wren, lane_en, NEW_ON_WRITE);

  always_ff @(posedge clk) begin
    if (lane_wr) cells[addr] <= wbyte;
  end
endmodule

// File: rtl/bram_out_stage.sv
module bram_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/bytelane_ram.sv
module bytelane_ram #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 4,
  parameter bit NEW_ON_WRITE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  input  logic                wren,
  input  logic                rden,
  input  logic [DATA_W/8-1:0] byteena,
  input  logic                addressstall,
  output logic [DATA_W-1:0]   q
);
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_lat;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] view_word;
  logic              out_load;

  assign out_load = wren || rden;

  bram_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_in (addr),
    .stall   (addressstall),
    .eff_addr(eff_addr),
    .addr_lat(addr_lat)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bram_lane #(.ADDR_W(ADDR_W), .NEW_ON_WRITE(NEW_ON_WRITE)) u_lane (
      .clk      (clk),
      .addr     (eff_addr),
      .wren     (wren),
      .lane_en  (byteena[i]),
      .wbyte    (data[8*i +: 8]),
      .old_byte (old_word[8*i +: 8]),
      .view_byte(view_word[8*i +: 8])
    );
  end

  bram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .load (out_load),
    .din  (view_word),
    .q    (q)
  );
endmodule

// File: rtl/bram_checker.sv
module bram_checker #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 4,
  parameter bit NEW_ON_WRITE = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   data,
  input logic                wren,
  input logic                rden,
  input logic [DATA_W/8-1:0] byteena,
  input logic                addressstall,
  input logic [DATA_W-1:0]   q,
  input logic [ADDR_W-1:0]   addr_lat,
  input logic [DATA_W-1:0]   old_word
);
  localparam int LANES = DATA_W / 8;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addressstall |=> addr_lat == $past(addr_lat));

  assert_addr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addressstall |=> addr_lat == $past(addr));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wren && !rden) |=> $stable(q));

  assert_read_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wren && rden) |=> q == $past(old_word));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_off_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wren && !byteena[i]) |=> q[8*i +: 8] == $past(old_word[8*i +: 8]));
    if (NEW_ON_WRITE) begin : g_new
      assert_new_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wren && byteena[i]) |=> q[8*i +: 8] == $past(data[8*i +: 8]));
    end else begin : g_old
      assert_old_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wren && byteena[i]) |=> q[8*i +: 8] == $past(old_word[8*i +: 8]));
    end
  end
endmodule

bind bytelane_ram bram_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NEW_ON_WRITE(NEW_ON_WRITE)
) u_chk (.*);

// File: tb/sim_bytelane_ram.sv
module sim_bytelane_ram;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int LN    = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          wren = 1'b0;
  logic          rden = 1'b0;
  logic [LN-1:0] byteena = '0;
  logic          addressstall = 1'b0;
  logic [DW-1:0] q_new, q_old;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [DW-1:0] model [DEPTH];
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] exp_new = '0, exp_old = '0;

  always #2 clk = ~clk;

  bytelane_ram #(.DATA_W(DW), .ADDR_W(AW), .NEW_ON_WRITE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .wren(wren),
    .rden(rden), .byteena(byteena), .addressstall(addressstall), .q(q_new));

  bytelane_ram #(.DATA_W(DW), .ADDR_W(AW), .NEW_ON_WRITE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .wren(wren),
    .rden(rden), .byteena(byteena), .addressstall(addressstall), .q(q_old));

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access: drive on the falling edge, one rising edge, compare at the
  // next falling edge.
  task automatic access(input string tag, input logic we, input logic re,
                        input logic [LN-1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic st);
    logic [AW-1:0] ea;
    logic [DW-1:0] prev;
    ea   = st ? m_addr : a;
    prev = model[ea];
    if (we) begin
      for (int l = 0; l < LN; l++) begin
        exp_old[8*l +: 8] = prev[8*l +: 8];
        exp_new[8*l +: 8] = be[l] ? d[8*l +: 8] : prev[8*l +: 8];
      end
      model[ea] = exp_new;
    end else if (re) begin
      exp_new = prev;
      exp_old = prev;
    end
    m_addr = ea;
    wren = we; rden = re; byteena = be; addr = a; data = d; addressstall = st;
    @(posedge clk);
    @(negedge clk);
    wren = 1'b0; rden = 1'b0; addressstall = 1'b0;
    check({tag, " new-view"}, q_new, exp_new);
    check({tag, " old-view"}, q_old, exp_old);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 q after reset", q_new, '0);
    check("R1 q after reset", q_old, '0);
    rst_n = 1'b1;
    m_addr = '0;
    // Stalled full write right after reset must land at address 0.
    access("R1 stalled write", 1'b1, 1'b0, 2'b11, 4'd9, 16'h1234, 1'b1);
    access("R1 read addr0", 1'b0, 1'b1, 2'b00, 4'd0, 16'h0000, 1'b0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++)
      access("R9 fill", 1'b1, 1'b0, 2'b11, AW'(i), 16'(16'h1111 * (i + 1)), 1'b0);
  endtask

  task automatic t_partial();
    access("R4 full write ABCD", 1'b1, 1'b0, 2'b11, 4'd3, 16'hABCD, 1'b0);
    access("R3 R4 be=10", 1'b1, 1'b0, 2'b10, 4'd3, 16'hFFFF, 1'b0);
    access("R2 readback FFCD", 1'b0, 1'b1, 2'b00, 4'd3, 16'h0, 1'b0);
    check("R2 stored FFCD", q_new, 16'hFFCD);
    access("R4 restore ABCD", 1'b1, 1'b0, 2'b11, 4'd3, 16'hABCD, 1'b0);
    access("R3 R5 be=01", 1'b1, 1'b0, 2'b01, 4'd3, 16'hFFFF, 1'b0);
    check("R4 view ABFF", q_new, 16'hABFF);
    check("R5 view ABCD", q_old, 16'hABCD);
    access("R2 readback ABFF", 1'b0, 1'b1, 2'b00, 4'd3, 16'h0, 1'b0);
    access("R3 be=00 no change", 1'b1, 1'b0, 2'b00, 4'd3, 16'h5555, 1'b0);
    access("R2 unchanged", 1'b0, 1'b1, 2'b00, 4'd3, 16'h0, 1'b0);
    check("R2 unchanged ABFF", q_old, 16'hABFF);
  endtask

  task automatic t_read_idle();
    access("R6 read 5", 1'b0, 1'b1, 2'b00, 4'd5, 16'h0, 1'b0);
    access("R6 read 6", 1'b0, 1'b1, 2'b00, 4'd6, 16'h0, 1'b0);
    access("R7 idle", 1'b0, 1'b0, 2'b11, 4'd1, 16'hDEAD, 1'b0);
    access("R7 idle again", 1'b0, 1'b0, 2'b00, 4'd2, 16'h0, 1'b0);
    check("R7 held read 6", q_new, 16'h7777);
  endtask

  task automatic t_stall();
    access("R8 load addr 10", 1'b0, 1'b1, 2'b00, 4'd10, 16'h0, 1'b0);
    access("R8 stalled write", 1'b1, 1'b0, 2'b01, 4'd2, 16'h00EE, 1'b1);
    access("R8 stalled write hi", 1'b1, 1'b0, 2'b10, 4'd4, 16'h9900, 1'b1);
    access("R8 stalled read", 1'b0, 1'b1, 2'b00, 4'd7, 16'h0, 1'b1);
    check("R8 held addr word", q_new, 16'h99EE);
    access("R8 stalled idle", 1'b0, 1'b0, 2'b00, 4'd0, 16'h0, 1'b1);
    access("R8 untouched 2", 1'b0, 1'b1, 2'b00, 4'd2, 16'h0, 1'b0);
    access("R8 untouched 4", 1'b0, 1'b1, 2'b00, 4'd4, 16'h0, 1'b0);
  endtask

  task automatic t_edges();
    access("R9 top write", 1'b1, 1'b0, 2'b11, AW'(DEPTH - 1), 16'hC3A5, 1'b0);
    access("R9 bottom write", 1'b1, 1'b0, 2'b10, 4'd0, 16'h5A00, 1'b0);
    access("R9 top read", 1'b0, 1'b1, 2'b00, AW'(DEPTH - 1), 16'h0, 1'b0);
    access("R9 bottom read", 1'b0, 1'b1, 2'b00, 4'd0, 16'h0, 1'b0);
    access("R9 back-to-back", 1'b1, 1'b1, 2'b11, 4'd0, 16'h0F0F, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9: actual=%0d cycles expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_partial();
    t_read_idle();
    t_stall();
    t_edges();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule